// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the horizontal timing of each line for an interline CCD. It runs on a clock at twice the pixel rate, so that every pixel period has a first and a second half. A phase bit and a line counter run from 1 to the line length. From them the block derives these outputs, all from registers:
- the line sync pulse;
- the complementary pair of horizontal shift clocks;
- the reset-gate pulse;
- a region code that tags every sample;
- an active-pixel index;
- the line count and an end-of-line strobe, which drive a vertical sequencer.

The readout order in a line is fixed: a dummy prescan, then two front black samples, then the effective pixels up to the last count. The rear black samples are read after the counter wraps to 1. A blanking span then follows, in which the vertical transfer happens. The shift clocks are frozen for part of that span, and the reset gate is silent for all of it.

Top module: `ccd_hline_gen`

## Requirements
- R1: While rst_ni is low, line_cnt_o is 1, h1_o is 1, h2_o is 0, rg_o is 0, eol_o is 0, hsync_o is 0, region_o is 2'b10 and pix_idx_o is 0.
- R2: After reset, line_cnt_o holds each value for exactly two clock cycles and counts 1, 2, …, 2280, then 1 again.
- R3: Outside counts 53 to 332, h1_o is high in the first clock cycle of each count and low in the second, and h2_o is always the inverse of h1_o.
- R4: For counts 53 to 332 inclusive, h1_o is held at 1 and h2_o at 0.
- R5: rg_o is high only in the first clock cycle of a count whose region is dummy, black or active, and only after the first clock edge following reset. It is low in every other cycle.
- R6: region_o is 2'b10 (black) for counts 1 to 52 and 629 to 630, 2'b00 (blank) for counts 53 to 600, 2'b01 (dummy) for counts 601 to 628, and 2'b11 (active) for counts 631 to 2280.
- R7: pix_idx_o is the line count minus 631 in the active region, which gives 0 to 1649, and 0 everywhere else.
- R8: eol_o is high in exactly one clock cycle per line: the second cycle of count 2280.
- R9: hsync_o is high for both clock cycles of count 228 and low otherwise.
- R10: Asserting rst_ni low in the middle of a line returns every output to its R1 value without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h1_o | output | 1 | Horizontal shift clock, phase 1 |
| h2_o | output | 1 | Horizontal shift clock, phase 2 |
| rg_o | output | 1 | Reset-gate pulse |
| hsync_o | output | 1 | Line sync pulse at count 228 |
| region_o | output | 2 | Region code of the current sample |
| pix_idx_o | output | 11 | Effective-pixel index, valid in the active region |
| line_cnt_o | output | 12 | Line count, 1 to 2280 |
| eol_o | output | 1 | End-of-line strobe |

## Verification
A behavioural model tracks the count and the phase, and the bench compares every output against it on every clock. The run covers two full lines from a clean reset. Those lines cross every region edge: the wrap from 2280 to 1 that leads into rear black, and both edges of the hold window. They also show apart the blank stretch in which the clocks run and the one in which they are frozen. A reset asserted between clock edges in mid line, followed by a further full line, checks the asynchronous return to the idle state and a clean restart from count 1, with the reset gate suppressed until the first edge.

// File: rtl/ccd_hline_pkg.sv
package ccd_hline_pkg;
  typedef enum logic [1:0] {
    REG_BLANK  = 2'b00,
    REG_DUMMY  = 2'b01,
    REG_BLACK  = 2'b10,
    REG_ACTIVE = 2'b11
  } region_e;
endpackage

// File: rtl/ccd_hline_cnt.sv
module ccd_hline_cnt #(
  parameter int LINE_LEN = 2280,
  parameter int CNT_W    = $clog2(LINE_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ph_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             ph_nxt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_LEN);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  always_comb begin
    ph_nxt_o  = ~ph_o;
    cnt_nxt_o = cnt_o;
    if (ph_o) cnt_nxt_o = (cnt_o == LAST) ? ONE : cnt_o + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= ONE;
      ph_o  <= 1'b0;
    end else begin
      cnt_o <= cnt_nxt_o;
      ph_o  <= ph_nxt_o;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o >= ONE && cnt_o <= LAST);
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_o |=> $stable(cnt_o) && ph_o);
  // R2
  cnt_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_o |=> !ph_o && !$stable(cnt_o));
endmodule

// File: rtl/ccd_hline_decode.sv
module ccd_hline_decode
  import ccd_hline_pkg::*;
#(
  parameter int LINE_LEN = 2280,
  parameter int PRE_LEN  = 28,
  parameter int FOB_LEN  = 2,
  parameter int ACT_LEN  = 1650,
  parameter int ROB_LEN  = 52,
  parameter int SYNC_POS = 228,
  parameter int CNT_W    = $clog2(LINE_LEN + 1),
  parameter int IDX_W    = $clog2(ACT_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             ph_nxt_i,
  output logic             readout_nxt_o,
  output region_e          region_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             eol_o,
  output logic             hsync_o
);
  localparam int ACT_FIRST = LINE_LEN - ACT_LEN + 1;
  localparam int FOB_FIRST = ACT_FIRST - FOB_LEN;
  localparam int PRE_FIRST = FOB_FIRST - PRE_LEN;

  region_e          region_n;
  logic [IDX_W-1:0] idx_n;
  logic             in_rob;

  // Rear black sits at the start of the count, after the wrap
  generate
    if (ROB_LEN > 0) begin : g_rob
      assign in_rob = cnt_nxt_i <= CNT_W'(ROB_LEN);
    end else begin : g_no_rob
      assign in_rob = 1'b0;
    end
  endgenerate

  always_comb begin
    region_n = REG_BLANK;
    if (in_rob)                                  region_n = REG_BLACK;
    else if (cnt_nxt_i >= CNT_W'(ACT_FIRST))     region_n = REG_ACTIVE;
    else if (cnt_nxt_i >= CNT_W'(FOB_FIRST))     region_n = REG_BLACK;
    else if (cnt_nxt_i >= CNT_W'(PRE_FIRST))     region_n = REG_DUMMY;
    idx_n = '0;
    if (region_n == REG_ACTIVE) idx_n = IDX_W'(cnt_nxt_i - CNT_W'(ACT_FIRST));
  end

  assign readout_nxt_o = region_n != REG_BLANK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_o <= REG_BLACK;
      idx_o    <= '0;
      eol_o    <= 1'b0;
      hsync_o  <= 1'b0;
    end else begin
      region_o <= region_n;
      idx_o    <= idx_n;
      eol_o    <= ph_nxt_i && (cnt_nxt_i == CNT_W'(LINE_LEN));
      hsync_o  <= cnt_nxt_i == CNT_W'(SYNC_POS);
    end
  end

  // R7
  idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_o != REG_ACTIVE |-> idx_o == '0);
  // R8
  eol_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> !eol_o && region_o == REG_BLACK);
  // R9
  hsync_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |=> hsync_o);
endmodule

// File: rtl/ccd_hline_hclk.sv
module ccd_hline_hclk #(
  parameter int HOLD_FIRST = 53,
  parameter int HOLD_LAST  = 332,
  parameter int CNT_W      = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             ph_nxt_i,
  input  logic             readout_nxt_i,
  output logic             h1_o,
  output logic             h2_o,
  output logic             rg_o
);
  logic hold_n, h1_n;

  assign hold_n = cnt_nxt_i >= CNT_W'(HOLD_FIRST) && cnt_nxt_i <= CNT_W'(HOLD_LAST);
  assign h1_n   = hold_n | ~ph_nxt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h1_o <= 1'b1;
      h2_o <= 1'b0;
      rg_o <= 1'b0;
    end else begin
      h1_o <= h1_n;
      h2_o <= ~h1_n;
      rg_o <= readout_nxt_i & ~ph_nxt_i & ~hold_n;
    end
  end

  // R3
  h_compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h1_o != h2_o);
  // R5
  rg_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |-> h1_o);
  // R5
  rg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |=> !rg_o);
endmodule

// File: rtl/ccd_hline_gen.sv
module ccd_hline_gen
  import ccd_hline_pkg::*;
#(
  parameter int LINE_LEN   = 2280,
  parameter int PRE_LEN    = 28,
  parameter int FOB_LEN    = 2,
  parameter int ACT_LEN    = 1650,
  parameter int ROB_LEN    = 52,
  parameter int HOLD_FIRST = 53,
  parameter int HOLD_LAST  = 332,
  parameter int SYNC_POS   = 228
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  output logic                              h1_o,
  output logic                              h2_o,
  output logic                              rg_o,
  output logic                              hsync_o,
  output logic [1:0]                        region_o,
  output logic [$clog2(ACT_LEN)-1:0]        pix_idx_o,
  output logic [$clog2(LINE_LEN + 1)-1:0]   line_cnt_o,
  output logic                              eol_o
);
  localparam int CNT_W = $clog2(LINE_LEN + 1);
  localparam int IDX_W = $clog2(ACT_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ph_q, ph_n, readout_n;
  region_e          region_q;

  ccd_hline_cnt #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .cnt_o(cnt_q), .ph_o(ph_q), .cnt_nxt_o(cnt_n), .ph_nxt_o(ph_n)
  );

  ccd_hline_decode #(
    .LINE_LEN(LINE_LEN), .PRE_LEN(PRE_LEN), .FOB_LEN(FOB_LEN), .ACT_LEN(ACT_LEN),
    .ROB_LEN(ROB_LEN), .SYNC_POS(SYNC_POS), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_dec (
    .clk_i, .rst_ni, .cnt_nxt_i(cnt_n), .ph_nxt_i(ph_n),
    .readout_nxt_o(readout_n), .region_o(region_q), .idx_o(pix_idx_o),
    .eol_o(eol_o), .hsync_o(hsync_o)
  );

  ccd_hline_hclk #(.HOLD_FIRST(HOLD_FIRST), .HOLD_LAST(HOLD_LAST), .CNT_W(CNT_W)) u_hclk (
    .clk_i, .rst_ni, .cnt_nxt_i(cnt_n), .ph_nxt_i(ph_n), .readout_nxt_i(readout_n),
    .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o)
  );

  assign region_o   = region_q;
  assign line_cnt_o = cnt_q;

  // R4
  hold_static_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CNT_W'(HOLD_FIRST) && cnt_q <= CNT_W'(HOLD_LAST)) |-> h1_o && !h2_o && !rg_o);
  // R5
  rg_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_q == REG_BLANK |-> !rg_o);
  // R8
  eol_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> cnt_q == CNT_W'(LINE_LEN) && ph_q);
endmodule

// File: tb/ccd_hline_gen_tb_top.sv
module ccd_hline_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_CYC   = 2 * 2280;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        h1, h2, rg, hsync, eol;
  logic [1:0]  region;
  logic [10:0] pix_idx;
  logic [11:0] line_cnt;

  int  n_cmp = 0, n_bad = 0;
  int  m_cnt = 1, m_ph = 0;
  bit  m_rgok = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_hline_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .h1_o(h1), .h2_o(h2), .rg_o(rg), .hsync_o(hsync),
    .region_o(region), .pix_idx_o(pix_idx), .line_cnt_o(line_cnt), .eol_o(eol)
  );

  // reference model: count and phase
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 1; m_ph = 0; m_rgok = 0;
    end else begin
      m_rgok = 1;
      if (m_ph == 1) begin
        m_cnt = (m_cnt == 2280) ? 1 : m_cnt + 1;
        m_ph  = 0;
      end else m_ph = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at t=%0t cnt=%0d ph=%0d: actual %0d expected %0d",
               tag, $time, m_cnt, m_ph, act, exp);
    end
  endtask

  task automatic compare_all(bit in_rst);
    int  e_reg, e_idx;
    bit  hold, e_h1;
    string pre;
    pre = in_rst ? "R1/R10 " : "";
    if (m_cnt <= 52)       e_reg = 2;
    else if (m_cnt <= 600) e_reg = 0;
    else if (m_cnt <= 628) e_reg = 1;
    else if (m_cnt <= 630) e_reg = 2;
    else                   e_reg = 3;
    e_idx = (e_reg == 3) ? m_cnt - 631 : 0;
    hold  = (m_cnt >= 53) && (m_cnt <= 332);
    e_h1  = hold || (m_ph == 0);
    chk({pre, "R2 line_cnt"}, int'(line_cnt), m_cnt);
    chk({pre, hold ? "R4 h1" : "R3 h1"}, int'(h1), int'(e_h1));
    chk({pre, hold ? "R4 h2" : "R3 h2"}, int'(h2), int'(!e_h1));
    chk({pre, "R5 rg"}, int'(rg), int'(m_rgok && e_reg != 0 && m_ph == 0 && !hold));
    chk({pre, "R6 region"}, int'(region), e_reg);
    chk({pre, "R7 pix_idx"}, int'(pix_idx), e_idx);
    chk({pre, "R8 eol"}, int'(eol), int'(m_cnt == 2280 && m_ph == 1));
    chk({pre, "R9 hsync"}, int'(hsync), int'(m_cnt == 228));
  endtask

  always @(negedge clk) if (!done) compare_all(!rst_n);

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * LINE_CYC + 1500) @(negedge clk);
    // R10: asynchronous reset between edges, mid line
    @(posedge clk);
    #(CLK_PERIOD/5);
    rst_n = 1'b0;
    #1;
    compare_all(1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (LINE_CYC + 300) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule